// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. It takes a 20-bit virtual page number, the root table frame of the current address space, and a flag that says whether the missing access is a store. It then fetches the entry indexed by the upper ten bits of the page number from the root table. That entry points to a second table, which it indexes with the lower ten bits. Each table holds 1024 four-byte entries, so it fills one 4 KB frame. The walker returns the frame number of the page, or a fault code.

On a successful walk the walker also maintains the replacement bookkeeping in the leaf entry. It sets the used bit on every reference, and it sets the dirty bit on a store. It writes the entry back only when one of these bits changes. Requests and responses use valid/ready handshakes. A request is accepted only while the walker is idle. A response stays on the port until the consumer takes it. Memory is reached through a single-word command channel (valid/ready) and a read-return channel that carries only a valid strobe. The return channel has no back-pressure, because at most one read is ever outstanding.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress and no response is pending. A request offered at any other time is not taken, and no memory command results from it.
- R2: The first read goes to byte address `{root_base, vpn[19:10], 2'b00}`.
- R3: The second read goes to byte address `{E1[31:12], vpn[9:0], 2'b00}`, where E1 is the first-level entry. Entry bits are: 0 present, 1 writable, 2 used, 3 dirty, 31:12 frame.
- R4: If an entry at either level has bit 0 clear, the walk ends with `rsp_fault` = 1 (absent) and `rsp_frame` = 0, and no write is issued.
- R5: A store whose leaf entry has bit 1 clear ends with `rsp_fault` = 2 (protection) and `rsp_frame` = 0, and no write is issued.
- R6: A walk that succeeds returns `rsp_fault` = 0 and `rsp_frame` = leaf entry bits 31:12.
- R7: On success, the leaf entry is written back to its own address. The value written is the entry with bit 2 set, and also bit 3 set when the walk is for a store.
- R8: No write is issued when the used bit (and, for a store, the dirty bit) is already set.
- R9: While `mem_cmd_ready` is low, a pending memory command keeps its address, direction and data unchanged. The walk gives the same result at any command acceptance rate.
- R10: While `rsp_ready` is low, the response stays valid and unchanged.
- R11: During and after reset, `req_ready` is 1, and `rsp_valid` and `mem_cmd_valid` are 0. A reset during a walk abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vpn | input | 20 | Virtual page number to translate |
| req_write | input | 1 | Missing access is a store |
| root_base | input | 20 | Frame number of the root table |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_frame | output | 20 | Physical frame number, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 protection |
| mem_cmd_valid | output | 1 | Memory command pending |
| mem_cmd_ready | input | 1 | Memory accepts command |
| mem_cmd_write | output | 1 | Command is a write |
| mem_cmd_addr | output | 32 | Byte address of the word |
| mem_cmd_wdata | output | 32 | Write data |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned word |

## Verification
The two interactions that can fall in the same cycle are a new request arriving while the previous response is still held by back-pressure, and a command stall arriving while the walker has a command pending. The bench holds `rsp_ready` low for several cycles while it offers a second request. It then judges that `req_ready` stays low, that the response does not change and that no further memory read appears. For the stall case, the bench runs a store walk that needs a write-back while the memory accepts commands only on alternate cycles. It then checks the returned frame, the written word and the written address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2, S_UPD, S_DONE, S_FLT
  } ptw_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } ptw_fault_e;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USED     = 2;
  localparam int BIT_DIRTY    = 3;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  second,
  input  logic [AW-OFF_W-1:0]   root_base,
  input  logic [AW-OFF_W-1:0]   next_base,
  input  logic [2*IDX_W-1:0]    vpn,
  output logic [AW-1:0]         addr
);
  localparam int ENT_LG = OFF_W - IDX_W;

  logic [IDX_W-1:0]    idx;
  logic [AW-OFF_W-1:0] base;

  always_comb begin
    idx  = second ? vpn[IDX_W-1:0] : vpn[2*IDX_W-1:IDX_W];
    base = second ? next_base : root_base;
    addr = {base, idx, {ENT_LG{1'b0}}};
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] pte,
  input  logic          is_store,
  output logic          absent,
  output logic          deny,
  output logic [PW-1:0] upd_pte,
  output logic          need_wb
);
  always_comb begin
    absent  = !pte[BIT_PRESENT];
    deny    = is_store && !pte[BIT_WRITABLE];
    upd_pte = pte;
    upd_pte[BIT_USED] = 1'b1;
    if (is_store) upd_pte[BIT_DIRTY] = 1'b1;
    need_wb = (upd_pte != pte);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int VPN_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic                req_write,
  input  logic [AW-OFF_W-1:0] req_root,
  output logic                req_ready,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [AW-OFF_W-1:0] rsp_frame,
  output logic [1:0]          rsp_fault,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_write,
  output logic [AW-1:0]       cmd_wdata,
  input  logic                rd_valid,
  input  logic [AW-OFF_W-1:0] rd_frame,
  input  logic                ev_absent,
  input  logic                ev_deny,
  input  logic [AW-1:0]       ev_upd,
  input  logic                ev_need_wb,
  output logic                lvl_two,
  output logic                is_store,
  output logic [VPN_W-1:0]    vpn_q,
  output logic [AW-OFF_W-1:0] root_q,
  output logic [AW-OFF_W-1:0] next_q
);
  ptw_state_e state;
  ptw_fault_e fault_q;
  logic       wait_rd;
  logic [AW-1:0] leaf_q;

  always_comb begin
    req_ready = (state == S_IDLE);
    rsp_valid = (state == S_DONE) || (state == S_FLT);
    rsp_frame = (state == S_DONE) ? leaf_q[AW-1:OFF_W] : '0;
    rsp_fault = (state == S_FLT) ? fault_q : FLT_NONE;
    cmd_valid = ((state == S_RD1 || state == S_RD2) && !wait_rd) || (state == S_UPD);
    cmd_write = (state == S_UPD);
    cmd_wdata = leaf_q;
    lvl_two   = (state == S_RD2) || (state == S_UPD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fault_q  <= FLT_NONE;
      wait_rd  <= 1'b0;
      leaf_q   <= '0;
      is_store <= 1'b0;
      vpn_q    <= '0;
      root_q   <= '0;
      next_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          vpn_q    <= req_vpn;
          is_store <= req_write;
          root_q   <= req_root;
          wait_rd  <= 1'b0;
          state    <= S_RD1;
        end
        S_RD1: begin
          if (!wait_rd && cmd_ready) wait_rd <= 1'b1;
          if (wait_rd && rd_valid) begin
            wait_rd <= 1'b0;
            if (ev_absent) begin
              fault_q <= FLT_ABSENT;
              state   <= S_FLT;
            end else begin
              next_q <= rd_frame;
              state  <= S_RD2;
            end
          end
        end
        S_RD2: begin
          if (!wait_rd && cmd_ready) wait_rd <= 1'b1;
          if (wait_rd && rd_valid) begin
            wait_rd <= 1'b0;
            if (ev_absent) begin
              fault_q <= FLT_ABSENT;
              state   <= S_FLT;
            end else if (ev_deny) begin
              fault_q <= FLT_PROT;
              state   <= S_FLT;
            end else begin
              leaf_q <= ev_upd;
              state  <= ev_need_wb ? S_UPD : S_DONE;
            end
          end
        end
        S_UPD:  if (cmd_ready) state <= S_DONE;
        S_DONE: if (rsp_ready) state <= S_IDLE;
        S_FLT:  if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2*IDX_W-1:0]    req_vpn,
  input  logic                  req_write,
  input  logic [AW-OFF_W-1:0]   root_base,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [AW-OFF_W-1:0]   rsp_frame,
  output logic [1:0]            rsp_fault,
  output logic                  mem_cmd_valid,
  input  logic                  mem_cmd_ready,
  output logic                  mem_cmd_write,
  output logic [AW-1:0]         mem_cmd_addr,
  output logic [AW-1:0]         mem_cmd_wdata,
  input  logic                  mem_rd_valid,
  input  logic [AW-1:0]         mem_rd_data
);
  localparam int VPN_W = 2 * IDX_W;
  localparam int FRM_W = AW - OFF_W;

  logic             lvl_two, is_store, ev_absent, ev_deny, ev_need_wb;
  logic [AW-1:0]    ev_upd;
  logic [VPN_W-1:0] vpn_q;
  logic [FRM_W-1:0] root_q, next_q;

  ptw_pte_eval #(.PW(AW)) u_eval (
    .pte(mem_rd_data), .is_store(is_store), .absent(ev_absent),
    .deny(ev_deny), .upd_pte(ev_upd), .need_wb(ev_need_wb)
  );

  ptw_addr_gen #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .second(lvl_two), .root_base(root_q), .next_base(next_q),
    .vpn(vpn_q), .addr(mem_cmd_addr)
  );

  ptw_ctrl #(.AW(AW), .OFF_W(OFF_W), .VPN_W(VPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
    .req_root(root_base), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_frame(rsp_frame), .rsp_fault(rsp_fault),
    .cmd_valid(mem_cmd_valid), .cmd_ready(mem_cmd_ready),
    .cmd_write(mem_cmd_write), .cmd_wdata(mem_cmd_wdata),
    .rd_valid(mem_rd_valid), .rd_frame(mem_rd_data[AW-1:OFF_W]),
    .ev_absent(ev_absent), .ev_deny(ev_deny), .ev_upd(ev_upd),
    .ev_need_wb(ev_need_wb), .lvl_two(lvl_two), .is_store(is_store),
    .vpn_q(vpn_q), .root_q(root_q), .next_q(next_q)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32,
  parameter int FW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [FW-1:0] rsp_frame,
  input logic [1:0]    rsp_fault,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic          mem_cmd_write,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [AW-1:0] mem_cmd_wdata
);
  p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_fault_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_frame == '0));

  p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3));

  p_wb_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_write) |-> (mem_cmd_wdata[0] && mem_cmd_wdata[2]));

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write) && $stable(mem_cmd_wdata)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) && $stable(rsp_fault)));

  p_idle_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cmd_valid);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .FW(AW - OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_frame(rsp_frame), .rsp_fault(rsp_fault),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
  .mem_cmd_wdata(mem_cmd_wdata)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [19:0] req_vpn = '0, root_base = 20'h00001;
  logic        req_ready, rsp_valid, mem_cmd_valid, mem_cmd_write;
  logic [19:0] rsp_frame;
  logic [1:0]  rsp_fault;
  logic [31:0] mem_cmd_addr, mem_cmd_wdata;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        stall = 1'b0, tog = 1'b0;
  logic        mem_cmd_ready;

  always #10 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_write(req_write), .root_base(root_base),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .rsp_fault(rsp_fault), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  // memory model: word array, one-cycle read latency, optional alternate-cycle accept
  logic [31:0] mem [0:4095];
  int          rcnt = 0, wcnt = 0;
  logic [31:0] rlog [0:63];
  logic [31:0] last_waddr = '0, last_wdata = '0;

  assign mem_cmd_ready = !stall || tog;

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rd_valid <= 1'b0;
    if (mem_cmd_valid && mem_cmd_ready) begin
      if (mem_cmd_write) begin
        mem[mem_cmd_addr[13:2]] <= mem_cmd_wdata;
        wcnt       <= wcnt + 1;
        last_waddr <= mem_cmd_addr;
        last_wdata <= mem_cmd_wdata;
      end else begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[mem_cmd_addr[13:2]];
        rlog[rcnt[5:0]] <= mem_cmd_addr;
        rcnt <= rcnt + 1;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic walk(input logic [19:0] vpn, input logic wr,
                      output logic [1:0] f, output logic [19:0] fr);
    @(negedge clk);
    req_vpn = vpn; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    f = rsp_fault; fr = rsp_frame;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [19:0] vpn;
    logic        wr;
    logic [1:0]  flt;
    logic [19:0] frm;
    logic        wb;
    logic [31:0] wd;
    logic [31:0] l2a;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{20'h00000, 1'b0, 2'd0, 20'h0000A, 1'b1, 32'h0000A005, 32'h00002000},
    '{20'h00000, 1'b0, 2'd0, 20'h0000A, 1'b0, 32'h0,        32'h00002000},
    '{20'h00001, 1'b1, 2'd0, 20'h0000B, 1'b0, 32'h0,        32'h00002004},
    '{20'h00002, 1'b1, 2'd0, 20'h0000C, 1'b1, 32'h0000C00F, 32'h00002008},
    '{20'h00003, 1'b1, 2'd2, 20'h00000, 1'b0, 32'h0,        32'h0000200C},
    '{20'h00003, 1'b0, 2'd0, 20'h0000D, 1'b1, 32'h0000D005, 32'h0000200C},
    '{20'h00004, 1'b0, 2'd1, 20'h00000, 1'b0, 32'h0,        32'h00002010},
    '{20'h00400, 1'b0, 2'd1, 20'h00000, 1'b0, 32'h0,        32'h0},
    '{20'h00800, 1'b1, 2'd0, 20'h0000E, 1'b1, 32'h0000E00F, 32'h00003000},
    '{20'h00800, 1'b0, 2'd0, 20'h0000E, 1'b0, 32'h0,        32'h00003000}
  };

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [1:0]  f;
    logic [19:0] fr;
    int          r0, w0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h400] = 32'h00002001;  // root idx 0 -> table at frame 2
    mem[12'h401] = 32'h00000000;  // root idx 1 absent
    mem[12'h402] = 32'h00003001;  // root idx 2 -> table at frame 3
    mem[12'h800] = 32'h0000A001;
    mem[12'h801] = 32'h0000B00F;
    mem[12'h802] = 32'h0000C003;
    mem[12'h803] = 32'h0000D001;
    mem[12'h804] = 32'h00000000;
    mem[12'h805] = 32'h0000F003;
    mem[12'hC00] = 32'h0000E007;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 req_ready in reset", {31'b0, req_ready}, 32'h1);
    chk("R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk("R11 mem_cmd_valid in reset", {31'b0, mem_cmd_valid}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      r0 = rcnt; w0 = wcnt;
      walk(VEC[i].vpn, VEC[i].wr, f, fr);
      chk($sformatf("R4 R5 R6 fault v%0d", i), {30'b0, f}, {30'b0, VEC[i].flt});
      chk($sformatf("R6 frame v%0d", i), {12'b0, fr}, {12'b0, VEC[i].frm});
      chk($sformatf("R2 first read addr v%0d", i), rlog[r0[5:0]],
          {20'h00001, VEC[i].vpn[19:10], 2'b00});
      if (VEC[i].l2a != 32'h0)
        chk($sformatf("R3 second read addr v%0d", i), rlog[(r0 + 1) % 64], VEC[i].l2a);
      else
        chk($sformatf("R4 single read v%0d", i), rcnt - r0, 32'd1);
      chk($sformatf("R7 R8 write count v%0d", i), wcnt - w0, {31'b0, VEC[i].wb});
      if (VEC[i].wb) begin
        chk($sformatf("R7 write data v%0d", i), last_wdata, VEC[i].wd);
        chk($sformatf("R7 write addr v%0d", i), last_waddr, VEC[i].l2a);
      end
    end

    // R1 R10: response back-pressure while a new request is offered
    walk(20'h00000, 1'b0, f, fr);
    @(negedge clk);
    req_vpn = 20'h00000; req_write = 1'b0; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_vpn = 20'h00001;
    while (!rsp_valid) @(negedge clk);
    r0 = rcnt;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 request held off", {31'b0, req_ready}, 32'h0);
      chk("R10 response held", {11'b0, rsp_valid, rsp_frame}, {11'b0, 1'b1, 20'h0000A});
    end
    chk("R1 no read while held", rcnt - r0, 32'd0);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // R9: command stall on alternate cycles, store walk with write-back
    stall = 1'b1;
    w0 = wcnt;
    walk(20'h00005, 1'b1, f, fr);
    chk("R9 frame under stall", {12'b0, fr}, 32'h0000F);
    chk("R9 write count under stall", wcnt - w0, 32'd1);
    chk("R9 write data under stall", last_wdata, 32'h0000F00F);
    chk("R9 write addr under stall", last_waddr, 32'h00002014);
    stall = 1'b0;

    // R11: reset during a walk
    @(negedge clk);
    req_vpn = 20'h00001; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 abandon req_ready", {31'b0, req_ready}, 32'h1);
    chk("R11 abandon rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R11 abandon cmd_valid", {31'b0, mem_cmd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    walk(20'h00001, 1'b0, f, fr);
    chk("R11 walk after reset", {10'b0, f, fr}, {10'b0, 2'd0, 20'h0000B});

    finish_run();
  end
endmodule